// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Pin Interrupts

The controller manages a bank of general-purpose pins through a small 32-bit register bus. Each access takes one cycle: address, write enable and write data are sampled on the rising clock edge, and read data is a combinational function of the address. Every pin has its own word-aligned configuration register. It holds enables for input, output, the output buffer and the interrupt, plus a three-bit trigger selector. Three shared registers follow the configuration block: the pending-interrupt status, the sampled pin inputs and the driven output values.

Pad inputs go through a two-flop synchronizer. A per-pin detector compares the synchronized value with its value one cycle earlier and finds level or edge conditions. An enabled condition latches a pending bit. The single interrupt output is high while any pending bit is set. Software acknowledges events by writing ones to the status register. A level condition that is still present latches again one cycle after it is cleared.

The design has no sequencing state machine. Its states are the per-pin pending flags (idle, pending), and it has two transitions: set on a qualified event, and clear on a write of one.

Top module: `pin_io_ctrl`

## Requirements
- R1: After reset, all configuration, output and status registers read zero, `irq` is low and `pad_oe` is all zero.
- R2: The configuration register of pin n sits at byte offset n*4. Its fields are: bit 0 output enable, bit 1 input enable, bit 2 output buffer enable, bit 3 interrupt enable, bits 7:5 trigger code. All other bits read zero.
- R3: `pad_oe[n]` is high exactly when both output enable and output buffer enable of pin n are set. `pad_out` follows the output register at offset 0x88, and that register reads back what was written.
- R4: The input register at offset 0x84 returns each pad value two clock edges after the pad changes. A bit reads zero while that pin's input enable is clear.
- R5: Trigger code 000 (level high) and 001 (level low) set the pin's pending bit while the synchronized pad is at that level.
- R6: Trigger code 010 (rising), 011 (falling) and 100 (both edges) set the pending bit on the matching transition of the synchronized pad.
- R7: Trigger codes 101, 110 and 111 never set a pending bit. No pending bit is set while the pin's interrupt enable is clear.
- R8: The status register at offset 0x80 holds one pending bit per pin. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. On the clearing edge the clear wins over a level condition, and a level still present sets the bit again on the next edge.
- R9: `irq` is high exactly when at least one pending bit is set.
- R10: Reads of any other offset return zero. A pad change becomes visible in the status register and on `irq` at the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pad_in | input | 32 | Asynchronous pad input values |
| pad_out | output | 32 | Values driven toward the pads |
| pad_oe | output | 32 | Per-pin pad drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the rising edge inside the write cycle, so the bench reads back on the following falling edge. An input-register change is due two edges after the pad moves. A pending bit and `irq` are due at the third edge. A level re-arm after a clear is due one edge after the clearing write. The bench changes pads and inputs only on falling edges and counts the edges to each sample point. It checks both the cycle before a result is due and the cycle it appears. For every pin and all eight trigger codes, a sweep walks through a low level, a rising edge and a falling edge. The expected status word is computed arithmetically from the trigger code.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;

    typedef enum logic [2:0] {
        TRIG_LVL_HI = 3'b000,
        TRIG_LVL_LO = 3'b001,
        TRIG_RISE   = 3'b010,
        TRIG_FALL   = 3'b011,
        TRIG_BOTH   = 3'b100
    } trig_e;

    typedef struct packed {
        trig_e trig;
        logic  irq_en;
        logic  buf_en;
        logic  in_en;
        logic  out_en;
    } pin_cfg_t;

    localparam int CFG_BIT_OUT = 0;
    localparam int CFG_BIT_IN  = 1;
    localparam int CFG_BIT_BUF = 2;
    localparam int CFG_BIT_IRQ = 3;
    localparam int CFG_TRIG_LO = 5;
    localparam int CFG_TRIG_HI = 7;

    function automatic pin_cfg_t cfg_from_word(input logic [7:0] w);
        pin_cfg_t c;
        c.out_en = w[CFG_BIT_OUT];
        c.in_en  = w[CFG_BIT_IN];
        c.buf_en = w[CFG_BIT_BUF];
        c.irq_en = w[CFG_BIT_IRQ];
        c.trig   = trig_e'(w[CFG_TRIG_HI:CFG_TRIG_LO]);
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_word(input pin_cfg_t c);
        return {c.trig, 1'b0, c.irq_en, c.buf_en, c.in_en, c.out_en};
    endfunction

endpackage

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] sync_prev
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign sync_out  = stage2_q;
    assign sync_prev = prev_q;
endmodule

// File: rtl/pin_event_det.sv
module pin_event_det
    import pin_io_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     cur,
    input  logic     prev,
    output logic     hit,
    output logic     is_level
);
    logic cond;

    always_comb begin
        cond     = 1'b0;
        is_level = 1'b0;
        unique case (cfg.trig)
            TRIG_LVL_HI: begin cond = cur;           is_level = 1'b1; end
            TRIG_LVL_LO: begin cond = !cur;          is_level = 1'b1; end
            TRIG_RISE:         cond = cur && !prev;
            TRIG_FALL:         cond = !cur && prev;
            TRIG_BOTH:         cond = cur ^ prev;
            default:           cond = 1'b0;
        endcase
        hit = cfg.irq_en && cond;
    end
endmodule

// File: rtl/pin_pending.sv
module pin_pending #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] level_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] pending
);
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] pend_d;

    always_comb begin
        pend_d = (pend_q & ~clr_vec)
               | (set_vec & ~level_vec)
               | (set_vec & level_vec & ~clr_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;
endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl
    import pin_io_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam int IDX_W = $clog2(NUM_PINS);
    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(NUM_PINS * 4);
    localparam logic [ADDR_W-1:0] OFS_INPUT  = ADDR_W'(NUM_PINS * 4 + 4);
    localparam logic [ADDR_W-1:0] OFS_OUTPUT = ADDR_W'(NUM_PINS * 4 + 8);

    pin_cfg_t            cfg_q [NUM_PINS];
    logic [NUM_PINS-1:0] out_q;
    logic [NUM_PINS-1:0] sync_cur;
    logic [NUM_PINS-1:0] sync_prev;
    logic [NUM_PINS-1:0] hit_vec;
    logic [NUM_PINS-1:0] level_vec;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] pending_q;
    logic [NUM_PINS-1:0] in_en_vec;
    logic [NUM_PINS-1:0] cfg_irq_en;

    logic             cfg_hit;
    logic [IDX_W-1:0] cfg_idx;

    assign cfg_hit = (bus_addr[1:0] == 2'b00) && (bus_addr < OFS_STATUS);
    assign cfg_idx = bus_addr[IDX_W+1:2];

    pin_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_cur),
        .sync_prev(sync_prev)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pin_event_det u_det (
            .cfg     (cfg_q[g]),
            .cur     (sync_cur[g]),
            .prev    (sync_prev[g]),
            .hit     (hit_vec[g]),
            .is_level(level_vec[g])
        );
        assign pad_oe[g]     = cfg_q[g].out_en && cfg_q[g].buf_en;
        assign in_en_vec[g]  = cfg_q[g].in_en;
        assign cfg_irq_en[g] = cfg_q[g].irq_en;
    end

    assign clr_vec = (bus_we && bus_addr == OFS_STATUS) ? bus_wdata[NUM_PINS-1:0] : '0;

    pin_pending #(.WIDTH(NUM_PINS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (hit_vec),
        .level_vec(level_vec),
        .clr_vec  (clr_vec),
        .pending  (pending_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= '0;
            out_q <= '0;
        end else if (bus_we) begin
            if (cfg_hit) cfg_q[cfg_idx] <= cfg_from_word(bus_wdata[7:0]);
            if (bus_addr == OFS_OUTPUT) out_q <= bus_wdata[NUM_PINS-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (cfg_hit)                      bus_rdata = DATA_W'(cfg_to_word(cfg_q[cfg_idx]));
        else if (bus_addr == OFS_STATUS)  bus_rdata = DATA_W'(pending_q);
        else if (bus_addr == OFS_INPUT)   bus_rdata = DATA_W'(sync_cur & in_en_vec);
        else if (bus_addr == OFS_OUTPUT)  bus_rdata = DATA_W'(out_q);
    end

    assign pad_out = out_q;
    assign irq     = |pending_q;
endmodule

// File: rtl/pin_io_ctrl_chk.sv
module pin_io_ctrl_chk #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [NUM_PINS-1:0] pending,
    input logic [NUM_PINS-1:0] irq_en,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq
);
    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(NUM_PINS * 4);

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pending == '0 && !irq && pad_oe == '0));

    assert_oe_after_cfg_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_oe[0]) |-> $past(bus_we && bus_addr == '0));

    assert_no_set_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending[0]) |-> $past(irq_en[0]));

    assert_sticky_until_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pending[0]) && !$past(bus_we && bus_addr == OFS_STATUS && bus_wdata[0]))
        |-> pending[0]);

    assert_irq_drop_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_we && bus_addr == OFS_STATUS));
endmodule

bind pin_io_ctrl pin_io_ctrl_chk #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .pending  (pending_q),
    .irq_en   (cfg_irq_en),
    .pad_oe   (pad_oe),
    .irq      (irq)
);

// File: tb/pin_io_ctrl_tb_top.sv
`timescale 1ns/1ps
module pin_io_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pin_io_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] bit_if(input bit c, input int p);
        return c ? (32'h1 << p) : 32'h0;
    endfunction

    initial begin
        #4000000;
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(8'h80, d); check("R1 status", d, 0);
        rd(8'h88, d); check("R1 output", d, 0);
        rd(8'h14, d); check("R1 cfg5", d, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 pad_oe", pad_oe, 0);

        // R2 config layout and addressing
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h44, d); check("R2 cfg17 fields", d, 32'h0000_00EF);
        rd(8'h48, d); check("R2 cfg18 untouched", d, 0);
        wr(8'h44, 32'h0);

        // R3 output drive
        wr(8'h14, 32'h5);
        wr(8'h18, 32'h1);
        wr(8'h88, 32'hA5A5_0020);
        rd(8'h88, d); check("R3 output readback", d, 32'hA5A5_0020);
        check("R3 pad_out", pad_out, 32'hA5A5_0020);
        check("R3 pad_oe only pin5", pad_oe, 32'h20);
        wr(8'h14, 32'h0); wr(8'h18, 32'h0);
        check("R3 pad_oe off", pad_oe, 0);

        // R4 input register with latency and gating
        wr(8'h24, 32'h2);
        pad_in = 32'h0000_0201;
        cyc(1); rd(8'h84, d); check("R4 input not yet", d, 0);
        cyc(1); rd(8'h84, d); check("R4 input after two edges", d, 32'h200);
        pad_in = 0; wr(8'h24, 32'h0); cyc(3);

        // R7 interrupt enable clear blocks pending
        wr(8'h08, 32'h02);
        pad_in = 32'h4; cyc(4);
        rd(8'h80, d); check("R7 irq_en clear", d, 0);
        pad_in = 0; wr(8'h08, 0); cyc(3);

        // R10 latency and R8 write-zero keeps bit
        wr(8'h0C, 32'h08);
        pad_in = 32'h8;
        cyc(2); check("R10 irq not at edge 2", {31'b0, irq}, 0);
        cyc(1); check("R10 irq at edge 3", {31'b0, irq}, 1);
        pad_in = 0; wr(8'h0C, 0); cyc(3);
        wr(8'h80, 32'hFFFF_FFF7);
        rd(8'h80, d); check("R8 write zero keeps bit", d, 32'h8);
        wr(8'h80, 32'h8);
        rd(8'h80, d); check("R8 write one clears", d, 0);

        // R10 unmapped offsets
        rd(8'h8C, d); check("R10 unmapped 0x8C", d, 0);
        rd(8'h02, d); check("R10 unaligned", d, 0);
        rd(8'hFC, d); check("R10 unmapped 0xFC", d, 0);

        // R5 R6 R7 R8 R9 sweep over every pin and trigger code
        for (int p = 0; p < 32; p++) begin
            for (int t = 0; t < 8; t++) begin
                wr(8'(p * 4), 32'h0A | (t << 5));
                cyc(3);
                wr(8'h80, 32'hFFFF_FFFF);
                rd(8'h80, d); check("R8 clear wins", d, 0);
                cyc(1);
                rd(8'h80, d); check("R5 level low rearm", d, bit_if(t == 1, p));
                check("R9 irq", {31'b0, irq}, {31'b0, d != 0});
                pad_in[p] = 1'b1; cyc(3);
                rd(8'h80, d);
                check("R6 rise", d, bit_if(t == 0 || t == 1 || t == 2 || t == 4, p));
                check("R9 irq", {31'b0, irq}, {31'b0, d != 0});
                wr(8'h80, 32'hFFFF_FFFF); cyc(1);
                rd(8'h80, d); check("R5 level high rearm", d, bit_if(t == 0, p));
                pad_in[p] = 1'b0; cyc(3);
                rd(8'h80, d);
                check("R6 fall", d, bit_if(t == 0 || t == 1 || t == 3 || t == 4, p));
                wr(8'h80, 32'hFFFF_FFFF); cyc(1);
                rd(8'h80, d); check("R7 R5 after fall", d, bit_if(t == 1, p));
                wr(8'(p * 4), 32'h0);
                wr(8'h80, 32'hFFFF_FFFF);
                rd(8'h80, d); check("R8 final clear", d, 0);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule